// File: doc/BRIEF.md
# Serial Master Controller with Slave-Ready Gating

This block is a serial peripheral master for one 16-bit word at a time. The host puts a word on `tx_data`, chooses clock polarity, clock phase, divider and handshake mode, and pulses `start`. The controller drives chip select low and generates the serial clock from the system clock. It sends the word most significant bit first on `mosi` and gathers the bits returned on `miso`. When the last bit has been taken, the received word appears on `rx_data` together with a one-cycle `done` pulse.

With the handshake option on, a transfer that has been accepted waits until the slave raises `rdy_in`. This input passes through a two-flop synchronizer first. As soon as the synchronized ready is seen, the transfer begins with no fixed guard time. A slow slave therefore holds the master back only for as long as it really needs.

The sequencer has five states:
- `ST_IDLE`: no transfer. `start` moves it to `ST_WAIT` when the handshake is on and to `ST_LEAD` when it is off.
- `ST_WAIT`: holds until the synchronized ready is high, then moves to `ST_LEAD`.
- `ST_LEAD`: chip select is low for one half period, then the block moves to `ST_SHIFT`.
- `ST_SHIFT`: runs 32 serial-clock edges. After the last edge it moves to `ST_DONE`.
- `ST_DONE`: one cycle that updates the receive buffer, then returns to `ST_IDLE`.

Top module: `spi_hs_master`

## Requirements
- R1: A `start` pulse while `busy` is low captures `tx_data`, `cfg_cpol`, `cfg_cpha`, `cfg_hs_en` and `cfg_div`. A `start` pulse while `busy` is high is ignored and produces no second transfer.
- R2: Data leaves on `mosi` most significant bit first. A slave samples `mosi` on the leading edge of each `sclk` period when `cfg_cpha`=0, and on the trailing edge when `cfg_cpha`=1. Such a slave receives the exact `tx_data` word in all four polarity/phase modes.
- R3: In every mode, `rx_data` holds the 16 bits that the slave drove on `miso`. The first bit received becomes bit 15.
- R4: `sclk` rests at `cfg_cpol` between transfers and returns to that level at the end of a transfer. Let H be `cfg_div`, or 1 when `cfg_div` is 0. Each half period of `sclk` lasts H clocks, and `cs_n` stays low for exactly 33·H+1 clocks per transfer.
- R5: With `cfg_hs_en`=1 and `rdy_in` low, an accepted transfer keeps `cs_n` high and `busy` high for as long as ready stays low.
- R6: With the handshake on, `cs_n` falls on the third rising clock edge after `rdy_in` goes high.
- R7: With `cfg_hs_en`=0, `rdy_in` has no effect: `cs_n` falls on the clock edge that samples `start`, even when `rdy_in` is low.
- R8: `busy` rises on the edge that samples an accepted `start`. `done` is high for exactly one cycle. In that cycle `busy` is low and `rx_data` already holds the new word.
- R9: After reset, `busy`=0, `done`=0, `cs_n`=1 and `rx_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_hs_en | input | 1 | Gate each transfer on the slave ready input |
| cfg_div | input | DIV_W | Half-period length in system clocks (0 treated as 1) |
| tx_data | input | WORD_W | Word to transmit |
| start | input | 1 | Request a transfer |
| rx_data | output | WORD_W | Last received word |
| busy | output | 1 | Transfer accepted and not yet finished |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |
| rdy_in | input | 1 | Asynchronous slave-ready input |

## Verification
The bench builds the block with its defaults, `WORD_W`=16 and `DIV_W`=8, and programs dividers from 0 to 4. Short half periods keep each transfer near a hundred clocks, so all four modes and several data patterns fit into one short run. The treatment of a divider of 0 as 1 and the exact `cs_n` low-time formula can both be checked within that run. A small divider also makes it practical to send a second `start` in the middle of a word, and to hold ready low across many clocks before releasing it.

// File: rtl/spi_hs_pkg.sv
package spi_hs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LEAD,
        ST_SHIFT,
        ST_DONE
    } state_t;
endpackage

// File: rtl/spi_hs_sync.sv
module spi_hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk) begin
        if (!rst_n) ff <= '0;
        else        ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/spi_hs_clkgen.sv
module spi_hs_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == half - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + DIV_W'(1);
    end
endmodule

// File: rtl/spi_hs_shifter.sv
module spi_hs_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         sample,
    input  logic         shift,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] word,
    output logic         held_bit
);
    logic [W-1:0] sh;
    logic         bit_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            bit_q <= 1'b0;
        end else begin
            if (load)        sh <= load_val;
            else if (shift)  sh <= {sh[W-2:0], bit_q};
            if (sample)      bit_q <= miso;
        end
    end

    assign mosi     = sh[W-1];
    assign word     = sh;
    assign held_bit = bit_q;
endmodule

// File: rtl/spi_hs_master.sv
module spi_hs_master
    import spi_hs_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_hs_en,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              start,
    output logic [WORD_W-1:0] rx_data,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n,
    input  logic              rdy_in
);
    localparam int EDGES  = 2 * WORD_W;
    localparam int EDGE_W = $clog2(EDGES);

    state_t state, nxt;

    logic              cpol_q, cpha_q, hs_q;
    logic [DIV_W-1:0]  half_q;
    logic [EDGE_W-1:0] edge_q;
    logic              sclk_q, done_q;
    logic [WORD_W-1:0] rx_q;
    logic              rdy_s, tick, run;
    logic              leading, shift_tick, last_edge;
    logic              load, sample_en, shift_en;
    logic [WORD_W-1:0] sh_word;
    logic              sh_bit;

    spi_hs_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rdy_in), .q(rdy_s)
    );

    assign run = (state == ST_LEAD) || (state == ST_SHIFT);

    spi_hs_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .run(run), .half(half_q), .tick(tick)
    );

    assign load       = (state == ST_IDLE) && start;
    assign leading    = ~edge_q[0];
    assign shift_tick = (state == ST_SHIFT) && tick;
    assign last_edge  = (edge_q == EDGE_W'(EDGES - 1));
    assign sample_en  = shift_tick && (leading ^ cpha_q);
    assign shift_en   = shift_tick && !(leading ^ cpha_q)
                        && !(cpha_q && edge_q == '0);

    spi_hs_shifter #(.W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(tx_data),
        .sample(sample_en), .shift(shift_en), .miso(miso),
        .mosi(mosi), .word(sh_word), .held_bit(sh_bit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start)  nxt = cfg_hs_en ? ST_WAIT : ST_LEAD;
            ST_WAIT:  if (rdy_s)  nxt = ST_LEAD;
            ST_LEAD:  if (tick)   nxt = ST_SHIFT;
            ST_SHIFT: if (tick && last_edge) nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
            hs_q   <= 1'b0;
            half_q <= DIV_W'(1);
            edge_q <= '0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
            rx_q   <= '0;
        end else begin
            done_q <= (state == ST_DONE);
            if (state == ST_IDLE) begin
                sclk_q <= cfg_cpol;
                edge_q <= '0;
                if (start) begin
                    cpol_q <= cfg_cpol;
                    cpha_q <= cfg_cpha;
                    hs_q   <= cfg_hs_en;
                    half_q <= (cfg_div == '0) ? DIV_W'(1) : cfg_div;
                end
            end
            if (shift_tick) begin
                sclk_q <= ~sclk_q;
                edge_q <= edge_q + EDGE_W'(1);
            end
            if (state == ST_DONE)
                rx_q <= cpha_q ? {sh_word[WORD_W-2:0], sh_bit} : sh_word;
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        cs_n    = !((state == ST_LEAD) || (state == ST_SHIFT) || (state == ST_DONE));
        done    = done_q;
        rx_data = rx_q;
        sclk    = sclk_q;
    end
endmodule

// File: rtl/spi_hs_master_chk.sv
module spi_hs_master_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic cs_n,
    input logic hs_q,
    input logic rdy_s
);
    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r5_cs_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    a_r6_gate_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && hs_q) |-> $past(rdy_s));
endmodule

bind spi_hs_master spi_hs_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .cs_n(cs_n), .hs_q(hs_q), .rdy_s(rdy_s)
);

// File: tb/spi_hs_master_bench.sv
module spi_hs_master_bench;
    localparam int W = 16;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_hs_en = 1'b0;
    logic [DW-1:0] cfg_div = 8'd1;
    logic [W-1:0] tx_data = '0;
    logic start = 1'b0;
    logic rdy_in = 1'b0;
    logic [W-1:0] rx_data;
    logic busy, done, sclk, mosi, miso, cs_n;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    spi_hs_master u_spi_hs_master (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_hs_en(cfg_hs_en), .cfg_div(cfg_div), .tx_data(tx_data),
        .start(start), .rx_data(rx_data), .busy(busy), .done(done),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .rdy_in(rdy_in)
    );

    // slave model
    logic [W-1:0] slv_word = '0;
    logic [W-1:0] slv_rx = '0;
    int  k = 0;
    logic cs_prev = 1'b1;
    logic samp_lvl;
    assign samp_lvl = ~(cfg_cpol ^ cfg_cpha);
    assign miso = (k < W) ? slv_word[W-1-k] : 1'b0;

    always @(cs_n or sclk) begin
        if (!cs_n && cs_prev) begin
            k = 0;
            slv_rx = '0;
        end else if (!cs_n && sclk == samp_lvl && k < W) begin
            slv_rx = {slv_rx[W-2:0], mosi};
            k = k + 1;
        end
        cs_prev = cs_n;
    end

    int done_cnt = 0;
    always @(posedge clk) if (done) done_cnt <= done_cnt + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // waits for done, returns number of negedges with cs_n low
    task automatic wait_done(output int low_cnt, output bit seen);
        low_cnt = 0;
        seen = 1'b0;
        for (int i = 0; i < 4000 && !seen; i++) begin
            if (!cs_n) low_cnt++;
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    task automatic pulse_start(input logic [W-1:0] d);
        tx_data = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    typedef struct packed {
        logic          cpol;
        logic          cpha;
        logic [DW-1:0] div;
        logic [W-1:0]  tx;
        logic [W-1:0]  slv;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b0, 1'b0, 8'd1, 16'hA55A, 16'h3C96},
        '{1'b0, 1'b1, 8'd2, 16'h8001, 16'hFFFF},
        '{1'b1, 1'b0, 8'd3, 16'h1234, 16'h0001},
        '{1'b1, 1'b1, 8'd1, 16'hFFFF, 16'h8000},
        '{1'b0, 1'b0, 8'd0, 16'h0000, 16'hBEEF},
        '{1'b1, 1'b1, 8'd4, 16'hC3A5, 16'h5A5A},
        '{1'b0, 1'b1, 8'd1, 16'h7FFE, 16'h0F0F},
        '{1'b1, 1'b0, 8'd2, 16'h0F1E, 16'hE1F0}
    };

    initial begin
        #(10 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int lc;
        bit seen;
        int h;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(busy == 1'b0 && done == 1'b0, "R9 busy/done", {busy, done}, 0);
        chk(cs_n == 1'b1, "R9 cs_n", cs_n, 1);
        chk(rx_data == '0, "R9 rx_data", rx_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table of transfers, handshake off
        for (int v = 0; v < 8; v++) begin
            cfg_cpol = VEC[v].cpol;
            cfg_cpha = VEC[v].cpha;
            cfg_div  = VEC[v].div;
            cfg_hs_en = 1'b0;
            slv_word = VEC[v].slv;
            repeat (2) @(negedge clk);
            chk(sclk == cfg_cpol, "R4 idle sclk", sclk, cfg_cpol);
            pulse_start(VEC[v].tx);
            chk(busy == 1'b1 && cs_n == 1'b0, "R7/R8 start", {busy, cs_n}, 2);
            wait_done(lc, seen);
            h = (VEC[v].div == 0) ? 1 : int'(VEC[v].div);
            chk(seen, "R8 done seen", seen, 1);
            chk(rx_data == VEC[v].slv, "R3 rx word", rx_data, VEC[v].slv);
            chk(slv_rx == VEC[v].tx, "R2 slave word", slv_rx, VEC[v].tx);
            chk(busy == 1'b0, "R8 busy at done", busy, 0);
            chk(lc == 33 * h + 1, "R4 cs_n low time", lc, 33 * h + 1);
            @(negedge clk);
            chk(done == 1'b0, "R8 done one cycle", done, 0);
            chk(sclk == VEC[v].cpol, "R4 sclk returns", sclk, VEC[v].cpol);
        end

        // R7: ready low with handshake off
        rdy_in = 1'b0;
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_div = 8'd1; cfg_hs_en = 1'b0;
        slv_word = 16'h1111;
        pulse_start(16'h2222);
        chk(cs_n == 1'b0, "R7 ready ignored", cs_n, 0);
        wait_done(lc, seen);
        chk(rx_data == 16'h1111, "R7 rx", rx_data, 16'h1111);
        @(negedge clk);

        // R5/R6 handshake gating
        cfg_hs_en = 1'b1;
        cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_div = 8'd2;
        slv_word = 16'h6DB6;
        pulse_start(16'h9249);
        begin
            bit held = 1'b1;
            for (int i = 0; i < 60; i++) begin
                if (!(cs_n && busy && sclk == 1'b1)) held = 1'b0;
                @(negedge clk);
            end
            chk(held, "R5 held while not ready", held, 1);
        end
        rdy_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(cs_n == 1'b1, "R6 still high after 2 edges", cs_n, 1);
        @(negedge clk);
        chk(cs_n == 1'b0, "R6 low on third edge", cs_n, 0);
        wait_done(lc, seen);
        chk(rx_data == 16'h6DB6, "R6 rx after ready", rx_data, 16'h6DB6);
        chk(slv_rx == 16'h9249, "R6 slave word", slv_rx, 16'h9249);
        rdy_in = 1'b0;
        cfg_hs_en = 1'b0;
        @(negedge clk);

        // R1 start while busy ignored
        cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_div = 8'd1;
        slv_word = 16'h0A0A;
        repeat (2) @(negedge clk);
        begin
            int d0;
            d0 = done_cnt;
            pulse_start(16'hCAFE);
            repeat (10) @(negedge clk);
            pulse_start(16'h1357);
            wait_done(lc, seen);
            chk(slv_rx == 16'hCAFE, "R1 first word kept", slv_rx, 16'hCAFE);
            repeat (80) @(negedge clk);
            chk(done_cnt - d0 == 1, "R1 single transfer", done_cnt - d0, 1);
            chk(cs_n == 1'b1 && busy == 1'b0, "R1 idle after", {cs_n, busy}, 2);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule